// File: doc/BRIEF.md
# Two-Wire Clock-Control Register Slave

This block lets a system controller set a small bank of clock-control registers, such as per-output enables, over a two-wire serial bus. It samples the clock and data lines with the system clock. It finds start and stop conditions, matches its device address and decodes a command byte. It then writes or returns register bytes, most significant bit first. The data line is driven only low, through an output-enable, so an external pull-up and wired-AND give the line level. All registers are presented in parallel on `reg_bus` for the clock logic.

The command byte selects the transfer. When its top bit is set, the low seven bits name a single register offset (indexed access). When the top bit is clear, the transfer is a block access that always starts at offset zero and moves upward one byte at a time. A block write carries a byte count before its data. A block read returns a byte count before its data. A read is started by a repeated start with the read address after the command byte. A transfer may be ended after any whole byte.

Top module: `clkctl_smb_slave`

## Requirements
- R1: After reset every register holds its parameter default (register i in `reg_bus[8*i+7:8*i]`) and `sda_oe` is 0.
- R2: The slave answers only the 7-bit address 69h: address byte D2h for a write and D3h for a read. Any other address byte gets no acknowledge, and the rest of that transfer has no effect.
- R3: Every address, command, count and write-data byte that is accepted is acknowledged: SDA is held low through the ninth SCL clock.
- R4: A command byte with bit 7 = 1 selects indexed access at the offset in bits 6:0. An indexed write changes only that register.
- R5: A command byte with bit 7 = 0 selects block access from offset 0. In a block write the first data byte is a count, which is acknowledged and not stored. The bytes that follow go to offsets 0, 1, 2 and upward.
- R6: A block write ended by a stop after any whole byte keeps the bytes already written. The registers it did not reach keep their values.
- R7: An indexed read (command, repeated start, D3h) returns the register at the chosen offset, most significant bit first.
- R8: A block read returns first a count equal to the number of registers, then the registers from offset 0 upward for as long as the master acknowledges.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more in that transfer.
- R10: Writes to offsets at or above the register count (up to 127) are acknowledged and discarded. Reads from those offsets return 00h.
- R11: `sda_oe` changes only while SCL is low, except at a start or stop condition. A stop always leaves SDA released.
- R12: Registers change only in response to an accepted write-data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_bus | output | NREG*8 | All control registers, register i in bits 8*i+7:8*i |

## Verification
On a read, one falling SCL edge does two things in the same system cycle: it ends the slave's acknowledge of the address (or the master's acknowledge) and it puts the first bit of the next read byte on the line. When that bit is 0, SDA must stay low without a glitch. When it is 1, SDA must be released at once. The bench reads registers whose top bit is 0 and others whose top bit is 1, right after an address acknowledge and right after a master acknowledge. A scoreboard compares every returned byte against a model of the register contents, so a lost or shifted first bit shows up as a wrong value.

// File: rtl/clkctl_smb_pkg.sv
package clkctl_smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA, ST_RCNT, ST_RDATA
  } smb_state_e;

  typedef enum logic [1:0] {
    PH_BITS, PH_ACK, PH_MACK
  } smb_phase_e;
endpackage

// File: rtl/clkctl_smb_sync.sv
module clkctl_smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkctl_smb_regbank.sv
module clkctl_smb_regbank #(
  parameter int                NREG     = 8,
  parameter int                AW       = 7,
  parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [7:0]        wdata,
  input  logic [AW-1:0]     raddr,
  output logic [7:0]        rdata,
  output logic [NREG*8-1:0] bus
);
  localparam int            IW    = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [AW-1:0] LIMIT = AW'(NREG);

  logic [7:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= DEFAULTS[i*8 +: 8];
    end else if (we && (waddr < LIMIT)) begin
      mem[waddr[IW-1:0]] <= wdata;
    end
  end

  always_comb begin
    rdata = (raddr < LIMIT) ? mem[raddr[IW-1:0]] : 8'h00;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_bus
    assign bus[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/clkctl_smb_slave.sv
module clkctl_smb_slave
  import clkctl_smb_pkg::*;
#(
  parameter int                NREG        = 8,
  parameter logic [6:0]        DEV_ADDR    = 7'h69,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NREG*8-1:0] DEFAULTS    = 64'h7E_FF_00_C3_5A_96_0F_F1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] reg_bus
);
  localparam int         AW         = 7;
  localparam logic [7:0] COUNT_BYTE = 8'(NREG);

  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  clkctl_smb_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_i), .q(scl_s));
  clkctl_smb_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .d(sda_i), .q(sda_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  smb_state_e    st;
  smb_phase_e    ph;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [AW-1:0] ptr;
  logic          saw_cmd, blk;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [7:0]    rd_data;
  logic [7:0]    tx_byte;
  logic          is_tx;

  clkctl_smb_regbank #(.NREG(NREG), .AW(AW), .DEFAULTS(DEFAULTS)) u_regs (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(ptr), .rdata(rd_data), .bus(reg_bus));

  assign is_tx   = (st == ST_RCNT) || (st == ST_RDATA);
  assign tx_byte = (st == ST_RCNT) ? COUNT_BYTE : rd_data;

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      st      <= ST_IDLE;
      ph      <= PH_BITS;
      bitcnt  <= '0;
      shreg   <= '0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
      saw_cmd <= 1'b0;
      blk     <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (start_det) begin
      st     <= ST_ADDR;
      ph     <= PH_BITS;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st      <= ST_IDLE;
      ph      <= PH_BITS;
      sda_oe  <= 1'b0;
      saw_cmd <= 1'b0;
    end else if (st != ST_IDLE) begin
      case (ph)
        PH_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            ph     <= PH_BITS;
            sda_oe <= 1'b0;
            if (is_tx) begin
              shreg  <= tx_byte;
              sda_oe <= ~tx_byte[7];
              if (st == ST_RCNT) st <= ST_RDATA;
              else if (ptr != '1) ptr <= ptr + 1'b1;
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            if (sda_s) begin
              st <= ST_IDLE;
              ph <= PH_BITS;
            end else begin
              ph <= PH_ACK;
            end
          end
        end
        default: begin
          if (is_tx) begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                ph     <= PH_MACK;
              end else if (bitcnt != 4'd0) begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end else if (scl_rise && (bitcnt < 4'd8)) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && (bitcnt == 4'd8)) begin
            ph     <= PH_ACK;
            sda_oe <= 1'b1;
            case (st)
              ST_ADDR: begin
                if (shreg[7:1] != DEV_ADDR) begin
                  st     <= ST_IDLE;
                  ph     <= PH_BITS;
                  sda_oe <= 1'b0;
                end else if (shreg[0]) begin
                  st <= (saw_cmd && blk) ? ST_RCNT : ST_RDATA;
                end else begin
                  st <= ST_CMD;
                end
              end
              ST_CMD: begin
                saw_cmd <= 1'b1;
                blk     <= ~shreg[7];
                ptr     <= shreg[7] ? shreg[6:0] : '0;
                st      <= shreg[7] ? ST_WDATA : ST_COUNT;
              end
              ST_COUNT: st <= ST_WDATA;
              ST_WDATA: begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                if (ptr != '1) ptr <= ptr + 1'b1;
              end
              default: begin
                st     <= ST_IDLE;
                ph     <= PH_BITS;
                sda_oe <= 1'b0;
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/clkctl_smb_chk.sv
module clkctl_smb_chk #(
  parameter int           W        = 64,
  parameter logic [W-1:0] DEFAULTS = '0
) (
  input logic         clk,
  input logic         rst,
  input logic         scl_s,
  input logic         start_det,
  input logic         stop_det,
  input logic         wr_en,
  input logic         sda_oe,
  input logic [W-1:0] reg_bus
);
  // R1
  reset_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (reg_bus == DEFAULTS) && !sda_oe);

  // R11
  sda_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(scl_s) && !$past(start_det) && !$past(stop_det) && !$past(rst))
      |-> $stable(sda_oe));

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R12
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rst)) |-> $stable(reg_bus));
endmodule

bind clkctl_smb_slave clkctl_smb_chk #(.W(NREG*8), .DEFAULTS(DEFAULTS)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .wr_en(wr_en), .sda_oe(sda_oe), .reg_bus(reg_bus));

// File: tb/test_clkctl_smb_slave.sv
module test_clkctl_smb_slave;
  localparam int          H    = 12;
  localparam int          Q    = 6;
  localparam logic [63:0] DEFV = 64'h7E_FF_00_C3_5A_96_0F_F1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [63:0] reg_bus;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  clkctl_smb_slave i_clkctl_smb_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_bus(reg_bus));

  typedef struct {string req; logic [7:0] val;} item_t;
  item_t exp_q[$];
  event got;
  logic [7:0] obs;
  int checks = 0;
  int errors = 0;
  logic [7:0] model [8];

  function automatic logic [63:0] packed_model();
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = model[i];
    return r;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    item_t it;
    @(got);
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL scoreboard: actual %02h expected nothing queued", obs);
    end else begin
      it = exp_q.pop_front();
      if (obs !== it.val) begin
        errors++;
        $display("FAIL %s: actual %02h expected %02h", it.req, obs, it.val);
      end
    end
  end

  task automatic bit_out(input logic b);
    tick(Q); sda_m = b; tick(H - Q); scl_m = 1'b1; tick(H); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    tick(Q); sda_m = 1'b1; tick(H - Q); scl_m = 1'b1; tick(Q);
    b = sda_line; tick(H - Q); scl_m = 1'b0;
  endtask

  task automatic do_start;
    if (scl_m == 1'b0) begin
      tick(Q); sda_m = 1'b1; tick(H - Q); scl_m = 1'b1; tick(H);
    end
    sda_m = 1'b0; tick(H); scl_m = 1'b0;
  endtask

  task automatic do_stop;
    tick(Q); sda_m = 1'b0; tick(H - Q); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    exp_q.push_back('{req, {7'b0, exp_ack}});
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    obs = {7'b0, ~a};
    ->got;
  endtask

  task automatic rd_byte(input logic [7:0] exp, input logic nack, input string req);
    logic [7:0] v;
    logic b;
    exp_q.push_back('{req, exp});
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(nack);
    obs = v;
    ->got;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = DEFV[i*8 +: 8];
    tick(10);
    rst = 1'b0;
    tick(5);
    check("R1", reg_bus, DEFV);
    check("R1", {63'b0, sda_oe}, 64'd0);

    // indexed write to offset 3
    do_start;
    wr_byte(8'hD2, 1'b1, "R2");
    wr_byte(8'h83, 1'b1, "R3");
    wr_byte(8'hA5, 1'b1, "R4");
    do_stop;
    tick(5);
    model[3] = 8'hA5;
    check("R4", reg_bus, packed_model());
    check("R11", {63'b0, sda_oe}, 64'd0);

    // foreign address: ignored
    do_start;
    wr_byte(8'hA4, 1'b0, "R2");
    wr_byte(8'h80, 1'b0, "R2");
    wr_byte(8'h11, 1'b0, "R2");
    do_stop;
    tick(5);
    check("R12", reg_bus, packed_model());

    // block write with count 3
    do_start;
    wr_byte(8'hD2, 1'b1, "R3");
    wr_byte(8'h00, 1'b1, "R5");
    wr_byte(8'h03, 1'b1, "R5");
    wr_byte(8'h11, 1'b1, "R5");
    wr_byte(8'h22, 1'b1, "R5");
    wr_byte(8'h33, 1'b1, "R5");
    do_stop;
    tick(5);
    model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
    check("R5", reg_bus, packed_model());

    // block write cut short
    do_start;
    wr_byte(8'hD2, 1'b1, "R6");
    wr_byte(8'h00, 1'b1, "R6");
    wr_byte(8'h08, 1'b1, "R6");
    wr_byte(8'h44, 1'b1, "R6");
    wr_byte(8'h55, 1'b1, "R6");
    do_stop;
    tick(5);
    model[0] = 8'h44; model[1] = 8'h55;
    check("R6", reg_bus, packed_model());

    // indexed write to last register
    do_start;
    wr_byte(8'hD2, 1'b1, "R4");
    wr_byte(8'h87, 1'b1, "R4");
    wr_byte(8'h3C, 1'b1, "R4");
    do_stop;
    tick(5);
    model[7] = 8'h3C;
    check("R4", reg_bus, packed_model());

    // indexed read, top bit 1
    do_start;
    wr_byte(8'hD2, 1'b1, "R7");
    wr_byte(8'h83, 1'b1, "R7");
    do_start;
    wr_byte(8'hD3, 1'b1, "R7");
    rd_byte(model[3], 1'b1, "R7");
    do_stop;
    tick(5);

    // indexed read, top bit 0
    do_start;
    wr_byte(8'hD2, 1'b1, "R7");
    wr_byte(8'h82, 1'b1, "R7");
    do_start;
    wr_byte(8'hD3, 1'b1, "R7");
    rd_byte(model[2], 1'b1, "R7");
    do_stop;
    tick(5);
    check("R12", reg_bus, packed_model());

    // block read: count, all registers, one beyond, then NACK
    do_start;
    wr_byte(8'hD2, 1'b1, "R8");
    wr_byte(8'h00, 1'b1, "R8");
    do_start;
    wr_byte(8'hD3, 1'b1, "R8");
    rd_byte(8'd8, 1'b0, "R8");
    for (int i = 0; i < 8; i++) rd_byte(model[i], 1'b0, "R8");
    rd_byte(8'h00, 1'b1, "R10");
    rd_byte(8'hFF, 1'b1, "R9");
    check("R9", {63'b0, sda_oe}, 64'd0);
    do_stop;
    tick(5);

    // out-of-range write and reads
    do_start;
    wr_byte(8'hD2, 1'b1, "R10");
    wr_byte(8'hD0, 1'b1, "R10");
    wr_byte(8'hFF, 1'b1, "R10");
    do_stop;
    tick(5);
    check("R10", reg_bus, packed_model());
    do_start;
    wr_byte(8'hD2, 1'b1, "R10");
    wr_byte(8'hFF, 1'b1, "R10");
    do_start;
    wr_byte(8'hD3, 1'b1, "R10");
    rd_byte(8'h00, 1'b1, "R10");
    do_stop;
    tick(5);

    // read address of another device
    do_start;
    wr_byte(8'hD5, 1'b0, "R2");
    do_stop;
    tick(5);
    check("R11", {63'b0, sda_oe}, 64'd0);

    tick(20);
    check("R12", 64'(exp_q.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule